// File: doc/BRIEF.md
# Passive LCD Scan Controller

This block scans a passive matrix LCD panel. It walks a frame buffer one nibble at a time through a word-read port and drives a 4-bit data bus. It also drives a line pulse, a frame pulse and an alternating drive signal that flips once per frame. The frame buffer holds 32-bit words, and each word is sent least-significant nibble first. Pixels are packed with no padding, so the scan itself does not depend on colour depth. The 2-bit depth select only produces a decoded pixel width for the colour stage that follows.

Software programs two counts. The first is the number of 4-bit transfers per line, minus one. In 8-bit colour this count is in red, green and blue sub-pixel transfers. The second is the number of line periods per frame, minus one. In split-panel mode each line period carries an upper-panel line and then a lower-panel line, so the programmed line count covers half the panel height.

The panel is driven only while both display-on and video-enable are set. A freeze request stops the scan at the next frame boundary, and the scan restarts from the top of the frame once freeze is cleared. A one-cycle end-of-frame pulse lets a DMA engine or software reload the buffer base.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: `pix_width` equals 1 shifted left by `cfg_depth`: select 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8.
- R2: Without split, a line period has `cfg_hcount`+1 consecutive cycles with `lcd_valid` high. These are followed by exactly one cycle with `lcd_line` high and `lcd_valid` low.
- R3: Transfer n of a frame (counted from 0) carries nibble n of the buffer. That nibble is bits [4*(n mod 8)+3 : 4*(n mod 8)] of word n/8, read at `fb_addr` = n/8.
- R4: With `cfg_invert` = 1, every valid transfer carries the bitwise complement of the buffer nibble.
- R5: A frame has `cfg_lines`+1 line periods. `lcd_frame` is high on every cycle of the first line period, line pulse included, and low elsewhere.
- R6: `frame_end` is high for one cycle, on the line pulse of the last line period. The next frame starts again at nibble 0, with no idle cycle in between.
- R7: `lcd_df` stays constant within a frame and inverts between consecutive frames.
- R8: In split mode, a line period holds 2*(`cfg_hcount`+1) transfers. Transfer x of the first half reads nibble line*(H+1)+x, with `lcd_lower` = 0. Transfer x of the second half reads nibble (L+1+line)*(H+1)+x, with `lcd_lower` = 1. Here H is `cfg_hcount` and L is `cfg_lines`.
- R9: While `cfg_disp_on` or `cfg_vid_en` is low, `lcd_valid`, `lcd_line`, `lcd_frame`, `lcd_lower` and `frame_end` are 0 and `lcd_data` is 0000, starting in the same cycle. Re-enabling restarts the scan at nibble 0, line 0.
- R10: Setting `cfg_freeze` mid-frame lets the frame finish, end-of-frame pulse included, and then holds all outputs quiet. Clearing `cfg_freeze` restarts the scan at the top of a frame on the next cycle.
- R11: During reset, all scan outputs are 0 and `lcd_df` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_depth | input | 2 | Pixel depth select |
| cfg_hcount | input | HCNT_W | Transfers per line minus one |
| cfg_lines | input | LINE_W | Line periods per frame minus one |
| cfg_split | input | 1 | Split-panel mode |
| cfg_invert | input | 1 | Invert all four data lines |
| cfg_disp_on | input | 1 | Display on |
| cfg_vid_en | input | 1 | Video logic enable |
| cfg_freeze | input | 1 | Stop at end of current frame |
| pix_width | output | 4 | Decoded pixel width in bits |
| fb_addr | output | ADDR_W | Frame buffer word address |
| fb_rdata | input | 32 | Frame buffer word at `fb_addr` (same cycle) |
| lcd_data | output | 4 | Panel data bus |
| lcd_valid | output | 1 | A transfer is on `lcd_data` |
| lcd_line | output | 1 | Line pulse |
| lcd_frame | output | 1 | Frame pulse (first line period) |
| lcd_df | output | 1 | Alternating drive signal |
| lcd_lower | output | 1 | Current transfer belongs to the lower panel |
| frame_end | output | 1 | One-cycle end-of-frame pulse |

## Verification
Three events can fall on the same cycle. The line pulse of the last line period is also the end-of-frame cycle, and in a one-line frame it also carries the frame pulse. The freeze decision, in turn, is made on that same boundary cycle. A one-line, one-transfer frame is scanned twice in a row to show line, frame and end-of-frame pulses high together, followed by an immediate restart at nibble 0 with the drive signal flipped. Freeze is raised mid-frame and the bench checks that the closing pulse still appears before the outputs go quiet.

// File: rtl/lcd_scan_pkg.sv
`timescale 1ns/1ps
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    DEPTH_MONO   = 2'd0,
    DEPTH_GREY2  = 2'd1,
    DEPTH_GREY4  = 2'd2,
    DEPTH_COLOR8 = 2'd3
  } depth_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_XFER   = 2'd1,
    ST_GAP    = 2'd2,
    ST_FROZEN = 2'd3
  } scan_st_e;

endpackage

// File: rtl/lcd_depth_decode.sv
`timescale 1ns/1ps
module lcd_depth_decode
  import lcd_scan_pkg::*;
(
  input  logic [1:0] depth,
  output logic [3:0] width
);

  depth_e sel;

  always_comb begin
    sel   = depth_e'(depth);
    width = 4'd1 << sel;
    if (!$isunknown(depth)) begin
      AST_WIDTH_ONEHOT: assert ($onehot(width)); // R1
    end
  end

endmodule

// File: rtl/lcd_nibble_out.sv
`timescale 1ns/1ps
module lcd_nibble_out #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0]               word,
  input  logic [$clog2(WORD_W/4)-1:0]     sel,
  input  logic                            valid,
  input  logic                            invert,
  output logic [3:0]                      data
);

  localparam int NIBS = WORD_W / 4;

  logic [3:0] nib_arr [NIBS];
  logic [3:0] picked;

  for (genvar k = 0; k < NIBS; k++) begin : g_split
    assign nib_arr[k] = word[4*k +: 4];
  end

  always_comb begin
    picked = nib_arr[sel];
    data   = valid ? (picked ^ {4{invert}}) : 4'b0000;
  end

endmodule

// File: rtl/lcd_scan_seq.sv
`timescale 1ns/1ps
module lcd_scan_seq
  import lcd_scan_pkg::*;
#(
  parameter int HCNT_W = 10,
  parameter int LINE_W = 9,
  parameter int PTR_W  = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              freeze,
  input  logic              split,
  input  logic [HCNT_W-1:0] hcount,
  input  logic [LINE_W-1:0] lines,
  output logic              xfer,
  output logic              gap,
  output logic              first_line,
  output logic              lower,
  output logic              eof,
  output logic              df,
  output logic [PTR_W-1:0]  ptr
);

  localparam int PROD_W = HCNT_W + LINE_W + 2;

  scan_st_e           st_q, st_n;
  logic [HCNT_W-1:0]  x_q, x_n;
  logic [LINE_W-1:0]  line_q, line_n;
  logic               half_q, half_n;
  logic [PTR_W-1:0]   up_q, up_n, lo_q, lo_n;
  logic               df_q, df_n;
  logic [PROD_W-1:0]  prod;
  logic [PTR_W-1:0]   lo_base;
  logic               last_line, last_x;

  always_comb begin
    prod      = (PROD_W'(hcount) + PROD_W'(1)) * (PROD_W'(lines) + PROD_W'(1));
    lo_base   = PTR_W'(prod);
    last_line = (line_q == lines);
    last_x    = (x_q == hcount);
  end

  // next-state process
  always_comb begin
    st_n   = st_q;
    x_n    = x_q;
    line_n = line_q;
    half_n = half_q;
    up_n   = up_q;
    lo_n   = lo_q;
    df_n   = df_q;
    unique case (st_q)
      ST_IDLE, ST_FROZEN: begin
        x_n    = '0;
        line_n = '0;
        half_n = 1'b0;
        up_n   = '0;
        lo_n   = lo_base;
        if (st_q == ST_IDLE || !freeze) st_n = ST_XFER;
      end
      ST_XFER: begin
        if (half_q) lo_n = lo_q + PTR_W'(1);
        else        up_n = up_q + PTR_W'(1);
        if (last_x) begin
          x_n = '0;
          if (split && !half_q) half_n = 1'b1;
          else                  st_n   = ST_GAP;
        end else begin
          x_n = x_q + HCNT_W'(1);
        end
      end
      ST_GAP: begin
        half_n = 1'b0;
        x_n    = '0;
        if (last_line) begin
          line_n = '0;
          up_n   = '0;
          lo_n   = lo_base;
          df_n   = ~df_q;
          st_n   = freeze ? ST_FROZEN : ST_XFER;
        end else begin
          line_n = line_q + LINE_W'(1);
          st_n   = ST_XFER;
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (!run) st_n = ST_IDLE;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      x_q    <= '0;
      line_q <= '0;
      half_q <= 1'b0;
      up_q   <= '0;
      lo_q   <= '0;
      df_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      x_q    <= x_n;
      line_q <= line_n;
      half_q <= half_n;
      up_q   <= up_n;
      lo_q   <= lo_n;
      df_q   <= df_n;
    end
  end

  assign xfer       = (st_q == ST_XFER);
  assign gap        = (st_q == ST_GAP);
  assign first_line = (line_q == '0);
  assign lower      = half_q;
  assign eof        = run && gap && last_line;
  assign df         = df_q;
  assign ptr        = half_q ? lo_q : up_q;

  AST_GAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP) |=> (st_q != ST_GAP)); // R2
  AST_DF_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> (df_q != $past(df_q))); // R7
  AST_DF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !eof |=> $stable(df_q)); // R7
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (st_q == ST_IDLE)); // R9
  AST_FREEZE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && freeze) |=> (st_q == ST_FROZEN)); // R10
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FROZEN && freeze && run) |=> (st_q == ST_FROZEN)); // R10

endmodule

// File: rtl/lcd_scan_ctrl.sv
`timescale 1ns/1ps
module lcd_scan_ctrl #(
  parameter int HCNT_W = 10,
  parameter int LINE_W = 9,
  parameter int ADDR_W = 16,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_depth,
  input  logic [HCNT_W-1:0] cfg_hcount,
  input  logic [LINE_W-1:0] cfg_lines,
  input  logic              cfg_split,
  input  logic              cfg_invert,
  input  logic              cfg_disp_on,
  input  logic              cfg_vid_en,
  input  logic              cfg_freeze,
  output logic [3:0]        pix_width,
  output logic [ADDR_W-1:0] fb_addr,
  input  logic [WORD_W-1:0] fb_rdata,
  output logic [3:0]        lcd_data,
  output logic              lcd_valid,
  output logic              lcd_line,
  output logic              lcd_frame,
  output logic              lcd_df,
  output logic              lcd_lower,
  output logic              frame_end
);

  localparam int SEL_W = $clog2(WORD_W / 4);
  localparam int PTR_W = ADDR_W + SEL_W;

  logic             run;
  logic             s_xfer, s_gap, s_first, s_lower, s_eof, s_df;
  logic [PTR_W-1:0] s_ptr;

  assign run = cfg_disp_on && cfg_vid_en;

  lcd_depth_decode u_depth (
    .depth (cfg_depth),
    .width (pix_width)
  );

  lcd_scan_seq #(
    .HCNT_W (HCNT_W),
    .LINE_W (LINE_W),
    .PTR_W  (PTR_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .freeze     (cfg_freeze),
    .split      (cfg_split),
    .hcount     (cfg_hcount),
    .lines      (cfg_lines),
    .xfer       (s_xfer),
    .gap        (s_gap),
    .first_line (s_first),
    .lower      (s_lower),
    .eof        (s_eof),
    .df         (s_df),
    .ptr        (s_ptr)
  );

  assign fb_addr   = s_ptr[PTR_W-1:SEL_W];
  assign lcd_valid = run && s_xfer;
  assign lcd_line  = run && s_gap;
  assign lcd_frame = run && (s_xfer || s_gap) && s_first;
  assign lcd_lower = run && s_xfer && s_lower;
  assign frame_end = s_eof;
  assign lcd_df    = s_df;

  lcd_nibble_out #(.WORD_W (WORD_W)) u_nib (
    .word   (fb_rdata),
    .sel    (s_ptr[SEL_W-1:0]),
    .valid  (lcd_valid),
    .invert (cfg_invert),
    .data   (lcd_data)
  );

  AST_BLANK_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_disp_on && cfg_vid_en) |-> (!lcd_valid && !lcd_line && lcd_data == 4'b0000)); // R9
  AST_EOF_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> lcd_line); // R6
  AST_LINE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_line |-> !lcd_valid); // R2

endmodule

// File: tb/test_lcd_scan_ctrl.sv
`timescale 1ns/1ps
module test_lcd_scan_ctrl;

  localparam int HCNT_W = 10;
  localparam int LINE_W = 9;
  localparam int ADDR_W = 16;

  logic              clk, rst_n;
  logic [1:0]        cfg_depth;
  logic [HCNT_W-1:0] cfg_hcount;
  logic [LINE_W-1:0] cfg_lines;
  logic              cfg_split, cfg_invert, cfg_disp_on, cfg_vid_en, cfg_freeze;
  logic [3:0]        pix_width;
  logic [ADDR_W-1:0] fb_addr;
  logic [31:0]       fb_rdata;
  logic [3:0]        lcd_data;
  logic              lcd_valid, lcd_line, lcd_frame, lcd_df, lcd_lower, frame_end;

  int checks = 0;
  int failures = 0;

  lcd_scan_ctrl #(.HCNT_W(HCNT_W), .LINE_W(LINE_W), .ADDR_W(ADDR_W)) i_lcd_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_hcount(cfg_hcount),
    .cfg_lines(cfg_lines), .cfg_split(cfg_split), .cfg_invert(cfg_invert),
    .cfg_disp_on(cfg_disp_on), .cfg_vid_en(cfg_vid_en), .cfg_freeze(cfg_freeze),
    .pix_width(pix_width), .fb_addr(fb_addr), .fb_rdata(fb_rdata),
    .lcd_data(lcd_data), .lcd_valid(lcd_valid), .lcd_line(lcd_line),
    .lcd_frame(lcd_frame), .lcd_df(lcd_df), .lcd_lower(lcd_lower),
    .frame_end(frame_end)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [3:0] nib_val(input int n);
    return 4'(((n & 15) + ((n >> 4) & 15) * 3 + ((n >> 8) & 15) * 5 + 9));
  endfunction

  always_comb begin
    for (int k = 0; k < 8; k++) fb_rdata[4*k +: 4] = nib_val(int'(fb_addr) * 8 + k);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] out_vec();
    return {lcd_valid, lcd_data, lcd_line, lcd_frame, frame_end, lcd_lower};
  endfunction

  task automatic sample_cmp(input logic [8:0] exp, input string req, output bit df_now);
    @(negedge clk);
    chk(out_vec() == exp, req, "{valid,data,line,frame,eof,lower}", int'(out_vec()), int'(exp));
    df_now = lcd_df;
  endtask

  // Scans one frame, checking every cycle. stop_after > 0 ends early.
  task automatic scan_frame(input int h, input int l, input bit sp, input bit inv,
                            input int stop_after, input int freeze_at, output bit df_seen);
    int c = 0;
    bit stop = 0;
    bit d_now;
    bit have_df = 0;
    for (int ln = 0; ln <= l && !stop; ln++) begin
      for (int hf = 0; hf < (sp ? 2 : 1) && !stop; hf++) begin
        for (int x = 0; x <= h && !stop; x++) begin
          int idx;
          logic [3:0] d;
          idx = sp ? (((hf == 1) ? (l + 1 + ln) : ln) * (h + 1) + x) : (ln * (h + 1) + x);
          d = nib_val(idx) ^ {4{inv}};
          sample_cmp({1'b1, d, 1'b0, ln == 0, 1'b0, hf == 1},
                     sp ? "R8 R3 R5" : (inv ? "R4 R3 R2" : "R3 R2 R5"), d_now);
          if (!have_df) begin df_seen = d_now; have_df = 1; end
          else chk(d_now == df_seen, "R7", "df within frame", int'(d_now), int'(df_seen));
          c++;
          if (c == freeze_at) cfg_freeze = 1'b1;
          if (c == stop_after) stop = 1;
        end
      end
      if (!stop) begin
        sample_cmp({1'b0, 4'b0000, 1'b1, ln == 0, ln == l, 1'b0}, "R2 R5 R6", d_now);
        chk(d_now == df_seen, "R7", "df within frame", int'(d_now), int'(df_seen));
        c++;
        if (c == freeze_at) cfg_freeze = 1'b1;
        if (c == stop_after) stop = 1;
      end
    end
  endtask

  task automatic start_scan(input int h, input int l, input bit sp, input bit inv);
    @(negedge clk);
    cfg_vid_en = 1'b0;
    cfg_freeze = 1'b0;
    @(negedge clk);
    cfg_hcount  = HCNT_W'(h);
    cfg_lines   = LINE_W'(l);
    cfg_split   = sp;
    cfg_invert  = inv;
    cfg_disp_on = 1'b1;
    cfg_vid_en  = 1'b1;
  endtask

  task automatic t_reset;
    #5;
    chk(out_vec() == 9'd0, "R11", "outputs in reset", int'(out_vec()), 0);
    chk(lcd_df == 1'b0, "R11", "df in reset", int'(lcd_df), 0);
  endtask

  task automatic t_width;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      cfg_depth = 2'(s);
      #1;
      chk(pix_width == 4'(1 << s), "R1", "pixel width", int'(pix_width), 1 << s);
    end
  endtask

  task automatic t_basic;
    bit df_a, df_b;
    start_scan(3, 2, 0, 0);
    scan_frame(3, 2, 0, 0, 0, 0, df_a);
    scan_frame(3, 2, 0, 0, 0, 0, df_b);
    chk(df_a != df_b, "R7", "df between frames", int'(df_b), int'(!df_a));
  endtask

  task automatic t_invert;
    bit df_a;
    start_scan(1, 1, 0, 1);
    scan_frame(1, 1, 0, 1, 0, 0, df_a);
  endtask

  task automatic t_tiny;
    bit df_a, df_b;
    start_scan(0, 0, 0, 0);
    scan_frame(0, 0, 0, 0, 0, 0, df_a);
    scan_frame(0, 0, 0, 0, 0, 0, df_b);
    chk(df_a != df_b, "R7", "df one-line frames", int'(df_b), int'(!df_a));
  endtask

  task automatic t_split;
    bit df_a;
    start_scan(2, 1, 1, 0);
    scan_frame(2, 1, 1, 0, 0, 0, df_a);
  endtask

  task automatic t_blank;
    bit df_a;
    start_scan(3, 2, 0, 0);
    scan_frame(3, 2, 0, 0, 5, 0, df_a);
    @(negedge clk);
    cfg_vid_en = 1'b0;
    #1;
    chk(out_vec() == 9'd0, "R9", "same-cycle blank (enable)", int'(out_vec()), 0);
    @(negedge clk);
    chk(out_vec() == 9'd0, "R9", "blank held", int'(out_vec()), 0);
    cfg_vid_en = 1'b1;
    scan_frame(3, 2, 0, 0, 6, 0, df_a);
    @(negedge clk);
    cfg_disp_on = 1'b0;
    #1;
    chk(out_vec() == 9'd0, "R9", "same-cycle blank (display)", int'(out_vec()), 0);
    @(negedge clk);
    cfg_disp_on = 1'b1;
    scan_frame(3, 2, 0, 0, 0, 0, df_a);
  endtask

  task automatic t_freeze;
    bit df_a, df_b, d_now;
    start_scan(1, 1, 0, 0);
    scan_frame(1, 1, 0, 0, 0, 2, df_a);
    for (int i = 0; i < 3; i++) begin
      sample_cmp(9'd0, "R10", d_now);
      chk(d_now != df_a, "R10", "df flipped on frozen boundary", int'(d_now), int'(!df_a));
    end
    cfg_freeze = 1'b0;
    scan_frame(1, 1, 0, 0, 0, 0, df_b);
    chk(df_b != df_a, "R10", "df after restart", int'(df_b), int'(!df_a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_depth = 2'd0; cfg_hcount = '0; cfg_lines = '0; cfg_split = 1'b0;
    cfg_invert = 1'b0; cfg_disp_on = 1'b1; cfg_vid_en = 1'b1; cfg_freeze = 1'b0;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_width();
    t_basic();
    t_invert();
    t_tiny();
    t_split();
    t_blank();
    t_freeze();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule